// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts down in two phases. Once started, the counter is loaded with a soft threshold. When that first countdown runs out, the block raises an interrupt and loads a second, margin-length hard threshold on its own. If no keepalive arrives before the second countdown ends, the block asserts a system reset. The reset stays asserted until the global synchronous reset clears the block. A keepalive at any point before then clears the interrupt and returns the block to the soft phase with a full soft count.

Software reaches the counter through a small 32-bit register bus. The bus gives access to a load register, the live count, a control word, a read-to-clear interrupt acknowledge and an interrupt status word. The thresholds are derived from a period and a margin given in seconds and a tick rate set by a parameter. New seconds values can be presented at run time, and the block refuses any that are out of range. Start, keepalive and release are plain strobes. The block carries no data stream, so it has no valid/ready interface and all pins are plain control and status.

A release strobe models the supervising software letting go of the watchdog. Depending on a mode pin, a release either refreshes the block for one last interval or fires the reset at once. In both cases, starting the watchdog again is blocked until the next global reset.

Top module: `wdt_two_stage`

## Requirements
- R1: After a synchronous `rst`, `sys_reset` and `irq` are 0, `wd_phase` is 0 (idle), `cfg_err` is 0, and reads of the load, current and control words return 0.
- R2: Word addresses are 0 load, 1 current count, 2 control, 3 interrupt acknowledge, 4 interrupt status. A bus write to word 0 sets the count and the load read-back at the next edge. `bus_rdata` is combinational while `bus_rd` is high, bit 0 of words 3 and 4 shows the pending interrupt, and any other address reads 0.
- R3: Bits [1:0] of the control word select the counter mode. 3 counts. 2 holds the count frozen. 0 stops the counter and returns `wd_phase` to idle, so no interrupt or reset follows.
- R4: While counting, the count drops by one on each clock with `tick_en` high and holds when `tick_en` is low. A load of N expires on the Nth tick, and the count then rests at 0.
- R5: `wd_start` while idle and not locked loads the soft threshold, (period − margin) × TICK_HZ, sets the control mode to 3 and moves `wd_phase` to 1 (soft). With the default 10 s period, 3 s margin and TICK_HZ 4, the soft threshold is 28.
- R6: A soft-phase expiry sets `irq`, loads the hard threshold, margin × TICK_HZ (12 by default), and moves `wd_phase` to 2 (hard) while counting continues.
- R7: A hard-phase expiry sets `sys_reset` and `wd_phase` 3 (fired). Both hold, and all other inputs are ignored, until `rst`.
- R8: `wd_kick` while started clears `irq`, reloads the soft threshold, sets the control mode to 3 and returns `wd_phase` to 1.
- R9: A bus read of word 3 clears `irq` at the read edge. A read of word 4 leaves it set.
- R10: An expiry while idle is spurious. It sets neither `irq` nor `sys_reset`.
- R11: `cfg_wr` accepts a period and margin only if 1 ≤ period ≤ 170, margin ≥ 1, margin ≤ 170 − period and margin < period. Otherwise `cfg_err` goes to 1 and the thresholds in use stay unchanged. An accepted pair clears `cfg_err`.
- R12: `wd_release` while started, with `force_on_release` low, acts as a keepalive and locks the block. After that, `wd_start` has no effect even after a stop.
- R13: `wd_release` while started, with `force_on_release` high, sets `sys_reset` and `wd_phase` 3 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| tick_en | input | 1 | Count-enable pulse, one decrement per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when `bus_rd` is low |
| wd_start | input | 1 | Start strobe |
| wd_kick | input | 1 | Keepalive strobe |
| wd_release | input | 1 | Release strobe |
| force_on_release | input | 1 | Release fires reset at once when high |
| cfg_wr | input | 1 | Present new period and margin |
| cfg_period | input | 8 | Total period in seconds |
| cfg_margin | input | 8 | Margin in seconds |
| cfg_err | output | 1 | Last presented configuration was rejected |
| irq | output | 1 | Soft-expiry interrupt pending |
| sys_reset | output | 1 | System reset, sticky |
| wd_phase | output | 2 | 0 idle, 1 soft, 2 hard, 3 fired |

## Verification
The assertions assume that strobes are single-cycle and that the counter expires only in the soft or hard phase once the block is started. They also assume the block is never reloaded over the bus while a hardware event is due in the same cycle. The stimulus drives every strobe for one clock, starting from the falling edge. It keeps bus writes to moments when no expiry, keepalive or start is pending, so each check sees the outcome of a single event. Tick gating is varied on purpose only in the scenario that targets it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SOFT  = 2'd1,
    PH_HARD  = 2'd2,
    PH_FIRED = 2'd3
  } wdt_phase_e;

  typedef enum logic [2:0] {
    ACT_BUS,
    ACT_FROZEN,
    ACT_ESCALATE,
    ACT_FIRE,
    ACT_REFRESH,
    ACT_START
  } wdt_act_e;

  localparam logic [2:0] A_LOAD = 3'd0;
  localparam logic [2:0] A_CURR = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  localparam logic [1:0] MODE_STOP = 2'b00;
  localparam logic [1:0] MODE_HOLD = 2'b10;
  localparam logic [1:0] MODE_RUN  = 2'b11;
endpackage

// File: rtl/wdt_cfg_check.sv
module wdt_cfg_check #(
  parameter int CNT_W      = 32,
  parameter int SEC_W      = 8,
  parameter int TICK_HZ    = 4,
  parameter int MAX_T      = 170,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_MARGIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [SEC_W-1:0] cfg_period,
  input  logic [SEC_W-1:0] cfg_margin,
  output logic [CNT_W-1:0] soft_thr,
  output logic [CNT_W-1:0] hard_thr,
  output logic             cfg_err
);
  localparam logic [CNT_W-1:0] SOFT_DEF = CNT_W'((DEF_PERIOD - DEF_MARGIN) * TICK_HZ);
  localparam logic [CNT_W-1:0] HARD_DEF = CNT_W'(DEF_MARGIN * TICK_HZ);
  localparam logic [CNT_W-1:0] MAX_V    = CNT_W'(MAX_T);
  localparam logic [CNT_W-1:0] HZ_V     = CNT_W'(TICK_HZ);

  logic [CNT_W-1:0] p_x, m_x, soft_calc, hard_calc;
  logic             ok;

  assign p_x       = CNT_W'(cfg_period);
  assign m_x       = CNT_W'(cfg_margin);
  assign soft_calc = (p_x - m_x) * HZ_V;
  assign hard_calc = m_x * HZ_V;
  assign ok = (p_x != '0) && (p_x <= MAX_V) && (m_x != '0) &&
              (m_x <= MAX_V - p_x) && (m_x < p_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_thr <= SOFT_DEF;
      hard_thr <= HARD_DEF;
      cfg_err  <= 1'b0;
    end else if (cfg_wr) begin
      cfg_err <= !ok;
      if (ok) begin
        soft_thr <= soft_calc;
        hard_thr <= hard_calc;
      end
    end
  end

  // R11: the error flag moves only when a configuration is presented
  a_r11_err_only_on_cfg: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_err));
  // R11: a rejected pair leaves the thresholds alone
  a_r11_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !ok) |=> $stable(soft_thr) && $stable(hard_thr));
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = run && tick && (count <= ONE);

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (load_en)       count <= load_val;
    else if (run && tick)   count <= (count <= ONE) ? '0 : count - ONE;
  end

  // R4: without a load the count never climbs
  a_r4_no_count_up: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> count <= $past(count));
  // R4: no tick or no run means the count is frozen
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !(run && tick)) |=> $stable(count));
  // R4: after an unreloaded expiry the count rests at zero
  a_r4_rest_at_zero: assert property (@(posedge clk) disable iff (rst)
    (expire && !load_en) |=> count == '0);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int CNT_W      = 32,
  parameter int SEC_W      = 8,
  parameter int TICK_HZ    = 4,
  parameter int MAX_T      = 170,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_MARGIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             wd_start,
  input  logic             wd_kick,
  input  logic             wd_release,
  input  logic             force_on_release,
  input  logic             cfg_wr,
  input  logic [SEC_W-1:0] cfg_period,
  input  logic [SEC_W-1:0] cfg_margin,
  output logic             cfg_err,
  output logic             irq,
  output logic             sys_reset,
  output logic [1:0]       wd_phase
);
  import wdt_pkg::*;

  wdt_phase_e       phase_q;
  wdt_act_e         act;
  logic [1:0]       mode_q;
  logic             irq_q, locked_q;
  logic [CNT_W-1:0] load_q, count, soft_thr, hard_thr, ld_val;
  logic             ld_en, expire, started, run;

  wdt_cfg_check #(
    .CNT_W(CNT_W), .SEC_W(SEC_W), .TICK_HZ(TICK_HZ), .MAX_T(MAX_T),
    .DEF_PERIOD(DEF_PERIOD), .DEF_MARGIN(DEF_MARGIN)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
    .cfg_margin(cfg_margin), .soft_thr(soft_thr), .hard_thr(hard_thr),
    .cfg_err(cfg_err)
  );

  wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_en(ld_en), .load_val(ld_val),
    .run(run), .tick(tick_en), .count(count), .expire(expire)
  );

  assign started = (phase_q != PH_IDLE);
  assign run     = (mode_q == MODE_RUN);

  always_comb begin
    act = ACT_BUS;
    if (phase_q == PH_FIRED)
      act = ACT_FROZEN;
    else if (expire && started)
      act = (phase_q == PH_SOFT) ? ACT_ESCALATE : ACT_FIRE;
    else if (wd_release && started && force_on_release)
      act = ACT_FIRE;
    else if ((wd_kick || wd_release) && started)
      act = ACT_REFRESH;
    else if (wd_start && !started && !locked_q)
      act = ACT_START;
  end

  always_comb begin
    ld_en  = 1'b0;
    ld_val = soft_thr;
    unique case (act)
      ACT_ESCALATE: begin ld_en = 1'b1; ld_val = hard_thr; end
      ACT_REFRESH, ACT_START: ld_en = 1'b1;
      ACT_BUS: begin
        ld_en  = bus_wr && (bus_addr == A_LOAD);
        ld_val = bus_wdata[CNT_W-1:0];
      end
      default: ld_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      mode_q   <= MODE_STOP;
      irq_q    <= 1'b0;
      locked_q <= 1'b0;
      load_q   <= '0;
    end else begin
      unique case (act)
        ACT_FROZEN: mode_q <= MODE_STOP;
        ACT_ESCALATE: begin
          irq_q   <= 1'b1;
          phase_q <= PH_HARD;
        end
        ACT_FIRE: begin
          phase_q  <= PH_FIRED;
          mode_q   <= MODE_STOP;
          locked_q <= locked_q | wd_release;
        end
        ACT_REFRESH: begin
          irq_q    <= 1'b0;
          phase_q  <= PH_SOFT;
          mode_q   <= MODE_RUN;
          locked_q <= locked_q | wd_release;
        end
        ACT_START: begin
          phase_q <= PH_SOFT;
          mode_q  <= MODE_RUN;
        end
        default: begin
          if (bus_wr && bus_addr == A_CTRL) begin
            mode_q <= bus_wdata[1:0];
            if (bus_wdata[1:0] == MODE_STOP) phase_q <= PH_IDLE;
          end
          if (bus_rd && bus_addr == A_ACK) irq_q <= 1'b0;
        end
      endcase
      if (ld_en) load_q <= ld_val;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_LOAD:         bus_rdata = 32'(load_q);
        A_CURR:         bus_rdata = 32'(count);
        A_CTRL:         bus_rdata = {30'd0, mode_q};
        A_ACK, A_STAT:  bus_rdata = {31'd0, irq_q};
        default:        bus_rdata = '0;
      endcase
    end
  end

  assign irq       = irq_q;
  assign sys_reset = (phase_q == PH_FIRED);
  assign wd_phase  = phase_q;

  // R7: once fired the reset never drops before the global reset
  a_r7_reset_sticky: assert property (@(posedge clk) disable iff (rst)
    sys_reset |=> sys_reset);
  // R6: a soft expiry escalates and interrupts
  a_r6_soft_escalates: assert property (@(posedge clk) disable iff (rst)
    (expire && phase_q == PH_SOFT) |=> irq && phase_q == PH_HARD && count == hard_thr);
  // R7: a hard expiry fires the reset
  a_r7_hard_fires: assert property (@(posedge clk) disable iff (rst)
    (expire && phase_q == PH_HARD) |=> sys_reset);
  // R10: an idle expiry raises neither output
  a_r10_spurious_quiet: assert property (@(posedge clk) disable iff (rst)
    (expire && phase_q == PH_IDLE) |=> !$rose(irq) && !sys_reset);
  // R12: a locked, idle block stays idle
  a_r12_locked_no_start: assert property (@(posedge clk) disable iff (rst)
    (locked_q && phase_q == PH_IDLE) |=> phase_q == PH_IDLE);
  // R8: a keepalive in a live phase clears the interrupt
  a_r8_kick_clears: assert property (@(posedge clk) disable iff (rst)
    (wd_kick && started && !sys_reset && !expire && !wd_release) |=> !irq && phase_q == PH_SOFT);
endmodule

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_start = 1'b0, wd_kick = 1'b0, wd_release = 1'b0;
  logic        force_on_release = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_period = '0, cfg_margin = '0;
  logic        cfg_err, irq, sys_reset;
  logic [1:0]  wd_phase;

  int checks = 0;
  int errors = 0;

  wdt_two_stage u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_start(wd_start), .wd_kick(wd_kick), .wd_release(wd_release),
    .force_on_release(force_on_release), .cfg_wr(cfg_wr),
    .cfg_period(cfg_period), .cfg_margin(cfg_margin), .cfg_err(cfg_err),
    .irq(irq), .sys_reset(sys_reset), .wd_phase(wd_phase)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic read_edge(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    cycles(1);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cycles(1);
    bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cycles(2); rst = 1'b0;
  endtask

  task automatic pulse_start();   wd_start = 1'b1;   cycles(1); wd_start = 1'b0;   endtask
  task automatic pulse_kick();    wd_kick = 1'b1;    cycles(1); wd_kick = 1'b0;    endtask
  task automatic pulse_release(); wd_release = 1'b1; cycles(1); wd_release = 1'b0; endtask

  task automatic present_cfg(input int p, input int m);
    cfg_period = 8'(p); cfg_margin = 8'(m); cfg_wr = 1'b1;
    cycles(1);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R1 sys_reset", 32'(sys_reset), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 phase", 32'(wd_phase), 0);
    check("R1 cfg_err", 32'(cfg_err), 0);
    peek(3'd2, d); check("R1 ctrl", d, 0);
    peek(3'd1, d); check("R1 current", d, 0);
    peek(3'd0, d); check("R1 load", d, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    do_reset();
    bus_write(3'd0, 32'h1234_5678);
    peek(3'd0, d); check("R2 load readback", d, 32'h1234_5678);
    peek(3'd1, d); check("R2 current after load", d, 32'h1234_5678);
    peek(3'd5, d); check("R2 unmapped", d, 0);
    bus_rd = 1'b0; bus_addr = 3'd1; #1;
    check("R2 rdata idle", bus_rdata, 0);
  endtask

  task automatic t_two_stage();
    logic [31:0] d;
    do_reset();
    pulse_start();
    peek(3'd1, d); check("R5 soft load", d, 28);
    check("R5 phase soft", 32'(wd_phase), 1);
    peek(3'd2, d); check("R5 ctrl run", d, 3);
    cycles(27);
    peek(3'd1, d); check("R4 count one left", d, 1);
    check("R4 no irq yet", 32'(irq), 0);
    cycles(1);
    check("R6 irq", 32'(irq), 1);
    check("R6 phase hard", 32'(wd_phase), 2);
    peek(3'd1, d); check("R6 hard load", d, 12);
    cycles(11);
    check("R7 not yet", 32'(sys_reset), 0);
    cycles(1);
    check("R7 reset", 32'(sys_reset), 1);
    check("R7 phase fired", 32'(wd_phase), 3);
    pulse_kick();
    cycles(5);
    check("R7 sticky", 32'(sys_reset), 1);
  endtask

  task automatic t_tick_gate();
    logic [31:0] d;
    do_reset();
    pulse_start();
    tick_en = 1'b0;
    cycles(5);
    peek(3'd1, d); check("R4 gated hold", d, 28);
    tick_en = 1'b1;
    cycles(3);
    peek(3'd1, d); check("R4 resumed", d, 25);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    do_reset();
    pulse_start();
    cycles(28);
    check("R8 irq before", 32'(irq), 1);
    pulse_kick();
    check("R8 irq cleared", 32'(irq), 0);
    check("R8 phase soft", 32'(wd_phase), 1);
    peek(3'd1, d); check("R8 soft reload", d, 28);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    do_reset();
    pulse_start();
    cycles(28);
    peek(3'd4, d); check("R9 status pending", d, 1);
    read_edge(3'd4, d);
    check("R9 status read keeps irq", 32'(irq), 1);
    read_edge(3'd3, d);
    check("R9 ack data", d, 1);
    check("R9 ack clears", 32'(irq), 0);
    check("R9 phase stays hard", 32'(wd_phase), 2);
  endtask

  task automatic t_spurious();
    logic [31:0] d;
    do_reset();
    bus_write(3'd0, 32'd5);
    bus_write(3'd2, 32'd3);
    cycles(10);
    peek(3'd1, d); check("R10 count drained", d, 0);
    check("R10 no irq", 32'(irq), 0);
    check("R10 no reset", 32'(sys_reset), 0);
    check("R10 idle", 32'(wd_phase), 0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    do_reset();
    pulse_start();
    cycles(4);
    bus_write(3'd2, 32'd2);
    cycles(5);
    peek(3'd1, d); check("R3 hold frozen", d, 23);
    bus_write(3'd2, 32'd3);
    cycles(2);
    peek(3'd1, d); check("R3 run resumes", d, 21);
    bus_write(3'd2, 32'd0);
    check("R3 stop idles", 32'(wd_phase), 0);
    cycles(60);
    peek(3'd1, d); check("R3 stopped count", d, 20);
    check("R3 no reset after stop", 32'(sys_reset), 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    do_reset();
    present_cfg(171, 3); check("R11 period too big", 32'(cfg_err), 1);
    present_cfg(6, 2);   check("R11 accept clears", 32'(cfg_err), 0);
    present_cfg(10, 0);  check("R11 zero margin", 32'(cfg_err), 1);
    present_cfg(160, 11); check("R11 margin over span", 32'(cfg_err), 1);
    present_cfg(5, 5);   check("R11 margin not below period", 32'(cfg_err), 1);
    pulse_start();
    peek(3'd1, d); check("R11 kept accepted soft", d, 16);
    cycles(16);
    check("R11 hard phase", 32'(wd_phase), 2);
    peek(3'd1, d); check("R11 kept accepted hard", d, 8);
  endtask

  task automatic t_release_soft();
    logic [31:0] d;
    do_reset();
    pulse_start();
    cycles(3);
    force_on_release = 1'b0;
    pulse_release();
    peek(3'd1, d); check("R12 refreshed", d, 28);
    check("R12 phase soft", 32'(wd_phase), 1);
    check("R12 no reset", 32'(sys_reset), 0);
    bus_write(3'd2, 32'd0);
    pulse_start();
    check("R12 restart blocked", 32'(wd_phase), 0);
    peek(3'd1, d); check("R12 count untouched", d, 27);
  endtask

  task automatic t_release_force();
    do_reset();
    pulse_start();
    cycles(2);
    force_on_release = 1'b1;
    pulse_release();
    force_on_release = 1'b0;
    check("R13 immediate reset", 32'(sys_reset), 1);
    check("R13 phase fired", 32'(wd_phase), 3);
  endtask

  initial begin
    #(CLK_T * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_regmap();
    t_two_stage();
    t_tick_gate();
    t_kick();
    t_ack();
    t_spurious();
    t_modes();
    t_cfg();
    t_release_soft();
    t_release_force();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule